// File: doc/BRIEF.md
# Micro-packet stream reassembler

This block takes in a stream of 32-bit micro-packet words and rebuilds 188-byte transport packets from them. Every word names one of four streams through a 3-bit tag, carries a start-of-packet flag, an overflow flag, a 3-bit rolling sequence count and three payload bytes. Each stream has its own reassembly context. The context holds a micro-packet counter, the last sequence value it saw and a one-packet byte buffer.

A packet is complete after 63 accepted micro-packets. The last of these contributes only two bytes. The completed packet then leaves on a valid/ready byte interface that marks the first and last bytes and names the stream. While a packet is being sent, the input is stalled. Per-stream one-cycle pulses report sequence gaps and overflows signalled by the source.

Top module: `mpr_reassembler`

## Requirements
- R1: A word whose tag field (bits 31:29) is 0, 5, 6 or 7 is discarded. It writes no payload, raises no flag and changes no stream context. A tag value t from 1 to 4 selects stream t-1.
- R2: A word with the start flag (bit 25) set is stored as micro-packet 0 of its stream. Any partial packet already in that stream is abandoned, and the packet that is sent is built only from the words that follow the start.
- R3: A word without the start flag that reaches a stream whose micro-packet counter is 0 is dropped. It raises no flag and does not update the sequence state.
- R4: A processed word with bit 24 set produces a one-cycle pulse on ovf_flag[stream] in the cycle after the word is accepted. No other bit of ovf_flag rises.
- R5: The sequence count is in bits 28:26. When a processed word's count is not the stream's previous count plus one (mod 8), loss_flag[stream] pulses for one cycle in the cycle after acceptance. The first processed word of a stream after reset is never flagged. Every processed word updates the stored count.
- R6: Micro-packet k places bits 23:16, 15:8 and 7:0 at packet bytes 3k, 3k+1 and 3k+2. For k = 62, bits 7:0 are discarded, which gives 188 bytes.
- R7: The 63rd processed word of a packet completes it. From the next cycle the block presents the 188 bytes in order on out_data with out_valid high. out_sop is high on byte 0 only, out_eop is high on byte 187 only, and out_sid holds the stream number.
- R8: While out_valid is high and out_ready is low, out_data, out_sid, out_sop and out_eop hold their values.
- R9: in_ready is low from the cycle after a completing word until the handshake of byte 187. It is high again in the cycle that follows that handshake.
- R10: The four streams keep separate counters, sequence state and buffers, so words from different streams may be interleaved freely.
- R11: After reset, in_ready is high, out_valid is low, both flag vectors are 0 and no stream holds sequence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Micro-packet word |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Packet byte |
| out_sid | output | 2 | Stream of the packet being sent |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| loss_flag | output | 4 | Per-stream sequence-gap pulse |
| ovf_flag | output | 4 | Per-stream source-overflow pulse |

## Verification
A wrong micro-packet counter in a stream shows up at the ports as bytes landing in the wrong positions of the next packet of that stream. It can also show up as a packet that completes early or late, or as unaligned words that are accepted when they should be dropped. All of these become visible within one packet's worth of words for that stream. A wrong sequence register shows up as a missing or spurious loss pulse in the very next cycle after that stream's next processed word. A faulty output sequencer shows up on the following byte as a misplaced sop/eop, a byte that changes under a stall, or an in_ready that does not return after the last byte.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  // Field layout of one micro-packet word, most significant field first.
  typedef struct packed {
    logic [2:0]  tag;      // stream number plus one
    logic [2:0]  seq;      // rolling sequence count
    logic        start;    // realigns the stream to micro-packet 0
    logic        ovf;      // source-side overflow indication
    logic [23:0] payload;  // three bytes, high byte first
  } mp_word_t;

  localparam int unsigned BYTES_PER_UP = 3;
  localparam int unsigned TAG_W        = 3;
endpackage

// File: rtl/mpr_lane.sv
module mpr_lane
  import mpr_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 188
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc,
  input  mp_word_t                     word,
  input  logic [$clog2(PKT_BYTES)-1:0] rd_idx,
  output logic [7:0]                   rd_byte,
  output logic                         done,
  output logic                         loss_q,
  output logic                         ovf_q
);
  localparam int unsigned UP_CNT = (PKT_BYTES + BYTES_PER_UP - 1) / BYTES_PER_UP;
  localparam int unsigned CNT_W  = $clog2(UP_CNT);
  localparam int unsigned IDX_W  = $clog2(PKT_BYTES);
  localparam int unsigned AW     = $clog2(BYTES_PER_UP * UP_CNT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             take, last_up;
  logic             seen_q, seen_d;
  logic [2:0]       last_q, last_d, last_inc;
  logic             seq_bad;

  logic [7:0]       mem [PKT_BYTES];
  logic [AW-1:0]    waddr [BYTES_PER_UP];
  logic [7:0]       wbyte [BYTES_PER_UP];

  // Alignment gate: only a start word or a word inside a packet is processed.
  assign base    = word.start ? '0 : cnt_q;
  assign take    = acc && (word.start || (cnt_q != '0));
  assign last_up = (base == CNT_W'(UP_CNT - 1));
  assign done    = take && last_up;

  assign last_inc = last_q + 3'd1;
  assign seq_bad  = seen_q && (word.seq != last_inc);

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    last_d = last_q;
    if (take) begin
      cnt_d  = last_up ? '0 : base + CNT_W'(1);
      seen_d = 1'b1;
      last_d = word.seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
      loss_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      last_q <= last_d;
      loss_q <= take && seq_bad;
      ovf_q  <= take && word.ovf;
    end
  end

  // Byte slots of the current micro-packet.
  for (genvar j = 0; j < BYTES_PER_UP; j++) begin : g_slot
    assign waddr[j] = AW'(base) * AW'(BYTES_PER_UP) + AW'(j);
    assign wbyte[j] = word.payload[23-8*j -: 8];
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BYTES_PER_UP; j++) begin
      if (take && (waddr[j] < AW'(PKT_BYTES))) begin
        mem[waddr[j][IDX_W-1:0]] <= wbyte[j];
      end
    end
  end

  assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/mpr_drain.sv
module mpr_drain #(
  parameter int unsigned PKT_BYTES = 188,
  parameter int unsigned SID_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [SID_W-1:0]             start_sid,
  input  logic                         out_ready,
  output logic                         busy,
  output logic [SID_W-1:0]             sid,
  output logic [$clog2(PKT_BYTES)-1:0] idx,
  output logic                         sop,
  output logic                         eop
);
  localparam int unsigned IDX_W = $clog2(PKT_BYTES);

  logic             busy_q, busy_d;
  logic [SID_W-1:0] sid_q, sid_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign eop = busy_q && (idx_q == IDX_W'(PKT_BYTES - 1));
  assign sop = busy_q && (idx_q == '0);

  always_comb begin
    busy_d = busy_q;
    sid_d  = sid_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sid_d  = start_sid;
        idx_d  = '0;
      end
    end else if (out_ready) begin
      if (eop) busy_d = 1'b0;
      else     idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sid_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sid_q  <= sid_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign sid  = sid_q;
  assign idx  = idx_q;
endmodule

// File: rtl/mpr_reassembler.sv
module mpr_reassembler
  import mpr_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 4,
  parameter int unsigned PKT_BYTES   = 188
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [31:0]                    in_word,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [7:0]                     out_data,
  output logic [$clog2(NUM_STREAMS)-1:0] out_sid,
  output logic                           out_sop,
  output logic                           out_eop,
  output logic [NUM_STREAMS-1:0]         loss_flag,
  output logic [NUM_STREAMS-1:0]         ovf_flag
);
  localparam int unsigned SID_W = $clog2(NUM_STREAMS);
  localparam int unsigned IDX_W = $clog2(PKT_BYTES);

  mp_word_t                word;
  logic                    accept;
  logic                    busy;
  logic [NUM_STREAMS-1:0]  done;
  logic [SID_W-1:0]        start_sid;
  logic [SID_W-1:0]        cur_sid;
  logic [IDX_W-1:0]        rd_idx;
  logic [7:0]              lane_byte [NUM_STREAMS];

  assign word     = in_word;
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_lane
    logic lane_acc;
    assign lane_acc = accept && (word.tag == TAG_W'(g + 1));
    mpr_lane #(.PKT_BYTES(PKT_BYTES)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (lane_acc),
      .word    (word),
      .rd_idx  (rd_idx),
      .rd_byte (lane_byte[g]),
      .done    (done[g]),
      .loss_q  (loss_flag[g]),
      .ovf_q   (ovf_flag[g])
    );
  end

  always_comb begin
    start_sid = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if (done[i]) start_sid = SID_W'(i);
    end
  end

  mpr_drain #(.PKT_BYTES(PKT_BYTES), .SID_W(SID_W)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (|done),
    .start_sid (start_sid),
    .out_ready (out_ready),
    .busy      (busy),
    .sid       (cur_sid),
    .idx       (rd_idx),
    .sop       (out_sop),
    .eop       (out_eop)
  );

  assign out_valid = busy;
  assign out_sid   = cur_sid;
  assign out_data  = lane_byte[cur_sid];
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker #(
  parameter int unsigned NUM_STREAMS = 4,
  parameter int unsigned PKT_BYTES   = 188
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic [31:0]                    in_word,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [7:0]                     out_data,
  input logic [$clog2(NUM_STREAMS)-1:0] out_sid,
  input logic                           out_sop,
  input logic                           out_eop,
  input logic [NUM_STREAMS-1:0]         loss_flag,
  input logic [NUM_STREAMS-1:0]         ovf_flag
);
  logic acc_bad_tag;
  assign acc_bad_tag = in_valid && in_ready &&
                       ((in_word[31:29] == 3'd0) || (in_word[31:29] > 3'(NUM_STREAMS)));

  p_invalid_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad_tag |=> ((loss_flag == '0) && (ovf_flag == '0) && !out_valid));

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_flag) |-> $past(in_valid && in_ready && in_word[24]));

  p_flag_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ovf_flag) && $onehot0(loss_flag));

  p_first_sop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);

  p_sop_eop_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sop && out_eop));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sid) &&
                                   $stable(out_sop) && $stable(out_eop)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> (!out_valid && in_ready));
endmodule

bind mpr_reassembler mpr_checker #(.NUM_STREAMS(NUM_STREAMS), .PKT_BYTES(PKT_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sid   (out_sid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .loss_flag (loss_flag),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_mpr_reassembler.sv
module sim_mpr_reassembler;
  localparam int NS  = 4;
  localparam int PB  = 188;
  localparam int UPC = 63;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [1:0]  out_sid;
  logic        out_sop, out_eop;
  logic [3:0]  loss_flag, ovf_flag;

  always #2 clk = ~clk;

  mpr_reassembler u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sid(out_sid),
    .out_sop(out_sop), .out_eop(out_eop), .loss_flag(loss_flag), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int fails  = 0;

  int         m_cnt  [NS];
  bit         m_seen [NS];
  int         m_last [NS];
  logic [7:0] m_buf  [NS][PB];
  int         g_seq  [NS];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int sq, input bit st, input bit ov,
                                     input logic [23:0] pl);
    return {tag[2:0], sq[2:0], st, ov, pl};
  endfunction

  // Reference model of the requirements; updates the model and returns expected pulses.
  task automatic model(input logic [31:0] w, output logic [3:0] el, output logic [3:0] eo,
                       output bit dn, output int ds);
    int tag, s, b, sq;
    el = '0; eo = '0; dn = 0; ds = 0;
    tag = int'(w[31:29]);
    if (tag == 0 || tag > NS) return;
    s = tag - 1;
    if (!w[25] && m_cnt[s] == 0) return;
    b = w[25] ? 0 : m_cnt[s];
    if (w[24]) eo[s] = 1'b1;
    sq = int'(w[28:26]);
    if (m_seen[s] && sq != ((m_last[s] + 1) % 8)) el[s] = 1'b1;
    m_seen[s] = 1;
    m_last[s] = sq;
    for (int j = 0; j < 3; j++) begin
      if (b * 3 + j < PB) m_buf[s][b*3+j] = w[23-8*j -: 8];
    end
    if (b == UPC - 1) begin
      m_cnt[s] = 0; dn = 1; ds = s;
    end else begin
      m_cnt[s] = b + 1;
    end
  endtask

  task automatic drain(input int s, input string req);
    int idx = 0;
    logic [7:0] prev = '0;
    bit stalled = 0;
    while (idx < PB) begin
      bit rdy = (($urandom % 4) != 0);
      out_ready = rdy;
      chk(out_valid == 1'b1, "R7", out_valid, 1);
      chk(out_data == m_buf[s][idx], req, out_data, m_buf[s][idx]);
      if (stalled) chk(out_data == prev, "R8", out_data, prev);
      chk(in_ready == 1'b0, "R9", in_ready, 0);
      chk(out_sid == 2'(s), "R7", out_sid, s);
      chk(out_sop == (idx == 0), "R7", out_sop, idx == 0);
      chk(out_eop == (idx == PB - 1), "R7", out_eop, idx == PB - 1);
      prev = out_data;
      stalled = !rdy;
      @(negedge clk);
      if (rdy) idx++;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic send(input logic [31:0] w, input string req);
    logic [3:0] el, eo;
    bit dn;
    int ds;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    model(w, el, eo, dn, ds);
    chk(loss_flag == el, req, loss_flag, el);
    chk(ovf_flag == eo, req, ovf_flag, eo);
    if (dn) drain(ds, req);
    else    chk(out_valid == 1'b0, "R7", out_valid, 0);
  endtask

  // n words of stream s starting with a start flag; optional seq fault and overflow.
  task automatic pkt(input int s, input int n, input int bad_at, input int ovf_at, input string req);
    for (int k = 0; k < n; k++) begin
      int sq = g_seq[s];
      if (k == bad_at) sq = (sq + 3) % 8;
      g_seq[s] = (sq + 1) % 8;
      send(mk(s + 1, sq, k == 0, k == ovf_at, 24'($urandom)), req);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin
      m_cnt[i] = 0; m_seen[i] = 0; m_last[i] = 0; g_seq[i] = 0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: state held during reset
    chk(in_ready == 1'b1, "R11", in_ready, 1);
    chk(out_valid == 1'b0, "R11", out_valid, 0);
    chk(loss_flag == 4'd0 && ovf_flag == 4'd0, "R11", {loss_flag, ovf_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R11", {in_ready, out_valid}, 2'b10);

    // R1: invalid tags carry start and overflow but must leave no trace
    send(mk(0, 1, 1, 1, 24'hAAAAAA), "R1");
    send(mk(5, 2, 1, 1, 24'hBBBBBB), "R1");
    send(mk(6, 3, 1, 1, 24'hCCCCCC), "R1");
    send(mk(7, 4, 1, 1, 24'hDDDDDD), "R1");

    // R3: unaligned word on a fresh stream is dropped, seq state untouched
    send(mk(3, 5, 0, 1, 24'h123456), "R3");
    send(mk(3, 0, 1, 0, 24'h010203), "R3");
    // R5: first processed word of stream 2 was not flagged (checked above); continue
    g_seq[2] = 1;
    for (int k = 1; k < UPC; k++) begin
      send(mk(3, g_seq[2], 0, 0, 24'($urandom)), "R6");
      g_seq[2] = (g_seq[2] + 1) % 8;
    end

    // R6: clean packet on stream 0
    pkt(0, UPC, -1, -1, "R6");
    // R5: sequence break in the middle of a stream 1 packet
    pkt(1, UPC, 10, -1, "R5");
    // R4: overflow flag on stream 3
    pkt(3, UPC, -1, 30, "R4");
    // R2: restart mid-packet, only the second run forms the packet
    pkt(0, 20, -1, -1, "R2");
    pkt(0, UPC, -1, -1, "R2");

    // R10: interleaved random traffic with occasional faults
    for (int n = 0; n < 2500; n++) begin
      int s = int'($urandom % NS);
      int r = int'($urandom % 100);
      int tag = s + 1;
      int sq;
      bit st;
      if (r < 5) tag = (r == 0) ? 0 : 4 + r % 4 + 1 - ((r % 4 == 3) ? 1 : 0);
      st = (m_cnt[s] == 0) ? (($urandom % 10) != 0) : (($urandom % 200) == 0);
      sq = (($urandom % 30) == 0) ? int'($urandom % 8) : g_seq[s];
      g_seq[s] = (sq + 1) % 8;
      send(mk(tag, sq, st, ($urandom % 40) == 0, 24'($urandom)), "R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule